// File: doc/BRIEF.md
# DLL Lane Enable Sequencer

This block brings up a group of per-lane delay-locked-loop control words after a single start pulse. One clock lane and a set of data lanes each own a 32-bit control word. The word holds a phase field, an active-low reset bit and a disable bit. The sequencer fills these words and steps them through a timed three-step release. First it places a lane in reset with its DLL disabled. It then clears the disable bit while reset stays asserted. Finally it releases reset and lets the lane settle before it moves on.

A single packed phase input supplies every phase value. Bits 21:16 feed the 6-bit clock-lane phase. The data lanes take successive 4-bit nibbles from bit 0 upward. The clock lane completes its whole sequence first. The configured data lanes then move through the same three steps in lockstep. How many data lanes are configured depends on a bus-width input. All hold times are counted in clock cycles from a cycles-per-microsecond parameter and run on one shared down-counter. A one-cycle done pulse marks the end of the sequence.

Top module: `dll_lane_seq`

## Requirements
- R1: After reset, every control word reads zero, `busy` is 0 and `done` is 0.
- R2: Clock-lane word layout: bit 31 is disable (1 = disabled), bit 30 is active-low reset (0 = in reset), bits 11:6 hold `phaseWord[21:16]`, and every other bit is 0.
- R3: Data-lane word layout for lane i (1-based, at `dataLaneCtl[32*(i-1) +: 32]`): bit 31 is disable, bit 30 is active-low reset, bits 17:14 hold `phaseWord[4*i-1 : 4*(i-1)]`, and every other bit is 0.
- R4: For each lane group the bits step in a fixed order. The first step is disable=1 with reset=0, held for 2*CYCLES_PER_US cycles. The second is disable=0 with reset=0, held for 22*CYCLES_PER_US cycles. The third is disable=0 with reset=1. A lane is never disabled while it is out of reset.
- R5: After a group's reset release, the sequencer waits a further 22*CYCLES_PER_US cycles before the group counts as ready.
- R6: No data-lane word changes while the clock lane runs its sequence. The data group's first step appears 46*CYCLES_PER_US cycles after the start edge.
- R7: With `wideBus`=1, data lanes 1 to 4 are configured. With `wideBus`=0, only lanes 1 and 2 are. Lanes that are not configured keep their previous words.
- R8: All configured data lanes change together, and their disable and reset bits are always equal.
- R9: The sequencer samples `phaseWord` and `wideBus` at the accepted start edge. A `start` pulse that arrives while `busy` is 1 is ignored, and so are later changes to `phaseWord` or `wideBus`.
- R10: `done` is a one-cycle pulse 92*CYCLES_PER_US cycles after the start edge. `busy` is 1 from the start edge until that cycle, when it is 0. All words keep their final values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence when idle |
| wideBus | input | 1 | 1 selects the 32-bit lane count, 0 the 16-bit lane count |
| phaseWord | input | 22 | Packed phases: clock lane at 21:16, data-lane nibbles from bit 0 |
| clkLaneCtl | output | 32 | Clock-lane DLL control word |
| dataLaneCtl | output | 128 | Data-lane control words, lane 1 in the low 32 bits |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a second start request, together with new phase and width inputs, that arrives while a sequence is running. If the design wrongly accepted it, the visible result would be a restarted or altered sequence. The stimulus raises `start` at the exact edge where the clock lane leaves its disable step. It also flips `phaseWord` and `wideBus` just after the accepted start. Every later word is then compared against values computed from the inputs captured at the start edge. A narrow run that follows a wide run checks that lanes 3 and 4 keep their old words.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

  localparam int CTL_W        = 32;
  localparam int DIS_BIT      = 31;
  localparam int NRST_BIT     = 30;
  localparam int CLK_PH_LSB   = 6;
  localparam int DATA_PH_LSB  = 14;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIS,
    ST_REL,
    ST_RUN
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic wrClk;
    logic wrData;
    logic nRst;
    logic dis;
  } seqStrobe_t;

endpackage

// File: rtl/dll_seq_ctrl.sv
module dll_seq_ctrl
  import dll_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 8,
  parameter int HOLD_DIS_US   = 2,
  parameter int HOLD_REL_US   = 22,
  parameter int HOLD_RUN_US   = 22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int DIS_CYC = HOLD_DIS_US * CYCLES_PER_US;
  localparam int REL_CYC = HOLD_REL_US * CYCLES_PER_US;
  localparam int RUN_CYC = HOLD_RUN_US * CYCLES_PER_US;
  localparam int MAX_A   = (DIS_CYC > REL_CYC) ? DIS_CYC : REL_CYC;
  localparam int MAX_CYC = (MAX_A > RUN_CYC) ? MAX_A : RUN_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] DIS_LD = CNT_W'(DIS_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LD = CNT_W'(REL_CYC - 1);
  localparam logic [CNT_W-1:0] RUN_LD = CNT_W'(RUN_CYC - 1);

  seqState_t        state, stateNext;
  logic             dataGroup, dataGroupNext;
  logic [CNT_W-1:0] waitCnt, waitCntNext;
  logic             doneNext;
  logic             cntZero;

  assign cntZero = (waitCnt == '0);

  always_comb begin
    strb          = '0;
    stateNext     = state;
    dataGroupNext = dataGroup;
    waitCntNext   = cntZero ? waitCnt : waitCnt - 1'b1;
    doneNext      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture  = 1'b1;
          strb.wrClk    = 1'b1;
          strb.dis      = 1'b1;
          dataGroupNext = 1'b0;
          waitCntNext   = DIS_LD;
          stateNext     = ST_DIS;
        end
      end
      ST_DIS: begin
        if (cntZero) begin
          strb.wrClk  = !dataGroup;
          strb.wrData = dataGroup;
          waitCntNext = REL_LD;
          stateNext   = ST_REL;
        end
      end
      ST_REL: begin
        if (cntZero) begin
          strb.wrClk  = !dataGroup;
          strb.wrData = dataGroup;
          strb.nRst   = 1'b1;
          waitCntNext = RUN_LD;
          stateNext   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (cntZero) begin
          if (!dataGroup) begin
            strb.wrData   = 1'b1;
            strb.dis      = 1'b1;
            dataGroupNext = 1'b1;
            waitCntNext   = DIS_LD;
            stateNext     = ST_DIS;
          end else begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      dataGroup <= 1'b0;
      waitCnt   <= '0;
      done      <= 1'b0;
    end else begin
      state     <= stateNext;
      dataGroup <= dataGroupNext;
      waitCnt   <= waitCntNext;
      done      <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/dll_seq_datapath.sv
module dll_seq_datapath
  import dll_seq_pkg::*;
#(
  parameter int LANES_WIDE   = 5,
  parameter int LANES_NARROW = 3,
  parameter int CLK_PH_W     = 6,
  parameter int DATA_PH_W    = 4,
  localparam int DATA_LANES  = LANES_WIDE - 1,
  localparam int NIB_W       = DATA_PH_W * DATA_LANES,
  localparam int PH_IN_W     = NIB_W + CLK_PH_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  strb,
  input  logic [PH_IN_W-1:0]          phaseWord,
  input  logic                        wideBus,
  output logic [CTL_W-1:0]            clkLaneCtl,
  output logic [CTL_W*DATA_LANES-1:0] dataLaneCtl
);

  logic [NIB_W-1:0]    heldNib;
  logic                heldWide;
  logic [CLK_PH_W-1:0] clkPhase;
  logic                clkDis, clkNRst;
  int                  activeLanes;

  assign activeLanes = heldWide ? LANES_WIDE : LANES_NARROW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldNib  <= '0;
      heldWide <= 1'b0;
      clkPhase <= '0;
      clkDis   <= 1'b0;
      clkNRst  <= 1'b0;
    end else begin
      if (strb.capture) begin
        heldNib  <= phaseWord[NIB_W-1:0];
        heldWide <= wideBus;
        clkPhase <= phaseWord[PH_IN_W-1:NIB_W];
      end
      if (strb.wrClk) begin
        clkDis  <= strb.dis;
        clkNRst <= strb.nRst;
      end
    end
  end

  always_comb begin
    clkLaneCtl = '0;
    clkLaneCtl[DIS_BIT]  = clkDis;
    clkLaneCtl[NRST_BIT] = clkNRst;
    clkLaneCtl[CLK_PH_LSB +: CLK_PH_W] = clkPhase;
  end

  for (genvar g = 0; g < DATA_LANES; g++) begin : gLane
    logic [DATA_PH_W-1:0] lanePhase;
    logic                 laneDis, laneNRst;
    logic                 laneOn;

    assign laneOn = (g + 1) < activeLanes;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lanePhase <= '0;
        laneDis   <= 1'b0;
        laneNRst  <= 1'b0;
      end else if (strb.wrData && laneOn) begin
        laneDis  <= strb.dis;
        laneNRst <= strb.nRst;
        if (strb.dis) begin
          lanePhase <= heldNib[g*DATA_PH_W +: DATA_PH_W];
        end
      end
    end

    always_comb begin
      dataLaneCtl[g*CTL_W +: CTL_W] = '0;
      dataLaneCtl[g*CTL_W + DIS_BIT]  = laneDis;
      dataLaneCtl[g*CTL_W + NRST_BIT] = laneNRst;
      dataLaneCtl[g*CTL_W + DATA_PH_LSB +: DATA_PH_W] = lanePhase;
    end
  end

endmodule

// File: rtl/dll_lane_seq.sv
module dll_lane_seq
  import dll_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 8,
  parameter int HOLD_DIS_US   = 2,
  parameter int HOLD_REL_US   = 22,
  parameter int HOLD_RUN_US   = 22,
  parameter int LANES_WIDE    = 5,
  parameter int LANES_NARROW  = 3,
  parameter int CLK_PH_W      = 6,
  parameter int DATA_PH_W     = 4,
  localparam int DATA_LANES   = LANES_WIDE - 1,
  localparam int PH_IN_W      = DATA_PH_W * DATA_LANES + CLK_PH_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        wideBus,
  input  logic [PH_IN_W-1:0]          phaseWord,
  output logic [CTL_W-1:0]            clkLaneCtl,
  output logic [CTL_W*DATA_LANES-1:0] dataLaneCtl,
  output logic                        busy,
  output logic                        done
);

  seqStrobe_t strb;

  dll_seq_ctrl #(
    .CYCLES_PER_US(CYCLES_PER_US),
    .HOLD_DIS_US  (HOLD_DIS_US),
    .HOLD_REL_US  (HOLD_REL_US),
    .HOLD_RUN_US  (HOLD_RUN_US)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .busy (busy),
    .done (done)
  );

  dll_seq_datapath #(
    .LANES_WIDE  (LANES_WIDE),
    .LANES_NARROW(LANES_NARROW),
    .CLK_PH_W    (CLK_PH_W),
    .DATA_PH_W   (DATA_PH_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .phaseWord  (phaseWord),
    .wideBus    (wideBus),
    .clkLaneCtl (clkLaneCtl),
    .dataLaneCtl(dataLaneCtl)
  );

endmodule

// File: rtl/dll_lane_seq_chk.sv
module dll_lane_seq_chk
  import dll_seq_pkg::*;
#(
  parameter int CYCLES_PER_US = 8,
  parameter int HOLD_DIS_US   = 2,
  parameter int DATA_LANES    = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busy,
  input logic                        done,
  input logic [CTL_W-1:0]            clkLaneCtl,
  input logic [CTL_W*DATA_LANES-1:0] dataLaneCtl
);

  localparam int DIS_CYC = HOLD_DIS_US * CYCLES_PER_US;

  logic [31:0] disRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) disRun <= '0;
    else if (clkLaneCtl[DIS_BIT]) disRun <= disRun + 1'b1;
    else disRun <= '0;
  end

  AST_CLK_DIS_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    clkLaneCtl[DIS_BIT] |-> !clkLaneCtl[NRST_BIT]); // R4

  AST_DATA_DIS_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    dataLaneCtl[DIS_BIT] |-> !dataLaneCtl[NRST_BIT]); // R4

  AST_DIS_HOLD_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkLaneCtl[DIS_BIT]) |-> (disRun == DIS_CYC)); // R4

  AST_DATA_WAITS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !clkLaneCtl[NRST_BIT]) |=> $stable(dataLaneCtl)); // R6

  AST_LANES_LOCKSTEP: assert property (@(posedge clk) disable iff (!rstN)
    dataLaneCtl[NRST_BIT +: 2] == dataLaneCtl[CTL_W + NRST_BIT +: 2]); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10

endmodule

bind dll_lane_seq dll_lane_seq_chk #(
  .CYCLES_PER_US(CYCLES_PER_US),
  .HOLD_DIS_US  (HOLD_DIS_US),
  .DATA_LANES   (DATA_LANES)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .clkLaneCtl (clkLaneCtl),
  .dataLaneCtl(dataLaneCtl)
);

// File: tb/tb_dll_lane_seq.sv
module tb_dll_lane_seq;

  localparam int C = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         wideBus = 1'b0;
  logic [21:0]  phaseWord = '0;
  logic [31:0]  clkLaneCtl;
  logic [127:0] dataLaneCtl;
  logic         busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [31:0] expData [1:4];

  always #4 clk = ~clk;

  dll_lane_seq #(.CYCLES_PER_US(C)) dut (
    .clk(clk), .rstN(rstN), .start(start), .wideBus(wideBus),
    .phaseWord(phaseWord), .clkLaneCtl(clkLaneCtl),
    .dataLaneCtl(dataLaneCtl), .busy(busy), .done(done)
  );

  function automatic logic [31:0] clkWord(logic [21:0] pw, logic nr, logic ds);
    return {ds, nr, 18'b0, pw[21:16], 6'b0};
  endfunction

  function automatic logic [31:0] dataWord(logic [3:0] nib, logic nr, logic ds);
    return {ds, nr, 12'b0, nib, 14'b0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic checkData(string tag, logic [21:0] pw, int lanes, bit cfg,
                           logic nr, logic ds);
    for (int i = 1; i <= 4; i++) begin
      logic [31:0] e;
      e = (cfg && i <= lanes) ? dataWord(pw[4*(i-1) +: 4], nr, ds) : expData[i];
      check(tag, dataLaneCtl[32*(i-1) +: 32], e);
    end
  endtask

  task automatic testReset();
    check("R1 clk word", clkLaneCtl, 32'h0);
    check("R1 data words", dataLaneCtl[31:0] | dataLaneCtl[63:32] |
          dataLaneCtl[95:64] | dataLaneCtl[127:96], 32'h0);
    check("R1 busy/done", {30'b0, busy, done}, 32'h0);
  endtask

  task automatic runSeq(logic [21:0] pw, bit wide, bit disturb);
    int lanes;
    lanes = wide ? 4 : 2;
    @(negedge clk);
    start = 1'b1; phaseWord = pw; wideBus = wide;
    @(posedge clk); #2;
    start = 1'b0;
    check("R2 R4 clk step1", clkLaneCtl, clkWord(pw, 1'b0, 1'b1));
    check("R10 busy after start", {31'b0, busy}, 32'h1);
    checkData("R6 data untouched", pw, lanes, 1'b0, 1'b0, 1'b0);
    if (disturb) begin
      phaseWord = ~pw; wideBus = !wide;
    end
    waitEdges(2*C-1);
    check("R4 step1 hold", clkLaneCtl, clkWord(pw, 1'b0, 1'b1));
    if (disturb) start = 1'b1;
    waitEdges(1);
    start = 1'b0;
    check("R4 R9 clk step2", clkLaneCtl, clkWord(pw, 1'b0, 1'b0));
    waitEdges(22*C-1);
    check("R4 step2 hold", clkLaneCtl, clkWord(pw, 1'b0, 1'b0));
    waitEdges(1);
    check("R4 clk step3", clkLaneCtl, clkWord(pw, 1'b1, 1'b0));
    waitEdges(22*C-1);
    check("R5 clk settled", clkLaneCtl, clkWord(pw, 1'b1, 1'b0));
    checkData("R5 R6 data wait", pw, lanes, 1'b0, 1'b0, 1'b0);
    waitEdges(1);
    checkData("R3 R7 R8 R9 data step1", pw, lanes, 1'b1, 1'b0, 1'b1);
    waitEdges(2*C);
    checkData("R4 R8 data step2", pw, lanes, 1'b1, 1'b0, 1'b0);
    waitEdges(22*C);
    checkData("R4 R8 data step3", pw, lanes, 1'b1, 1'b1, 1'b0);
    waitEdges(22*C-1);
    check("R5 R10 still busy", {30'b0, busy, done}, 32'h2);
    waitEdges(1);
    check("R10 done pulse", {30'b0, busy, done}, 32'h1);
    waitEdges(1);
    check("R10 done cleared", {30'b0, busy, done}, 32'h0);
    check("R10 clk final", clkLaneCtl, clkWord(pw, 1'b1, 1'b0));
    checkData("R7 R10 data final", pw, lanes, 1'b1, 1'b1, 1'b0);
    for (int i = 1; i <= lanes; i++) expData[i] = dataWord(pw[4*(i-1) +: 4], 1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 1; i <= 4; i++) expData[i] = 32'h0;
    repeat (3) @(posedge clk);
    #2;
    testReset();
    rstN = 1'b1;
    waitEdges(2);
    testReset();
    runSeq(22'h15_A5C3, 1'b1, 1'b0);
    runSeq(22'h2A_1234, 1'b0, 1'b1);
    runSeq(22'h3F_FFFF, 1'b1, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule